// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block sits beside an SMBus slave on the same clock and data lines. It answers the alert-response read, a read that a bus master issues after it sees the shared alert line pulled low. The master sends a START, then the reserved alert response address (7'b0001100) with the read bit set. While the local alert is asserted, the block acknowledges that address. It then transmits its own 7-bit device address as the data byte, most significant bit first. Once the master has taken that byte and closed the transfer with a STOP, the block raises a one-cycle `serviced` pulse so that the alert source can drop its request.

START and STOP detection is shared with the main slave. The block receives them as single-cycle pulses. `scl` and `sda` arrive already synchronised to `clk`. The block drives the bus only through `sda_pull`, which pulls the open-drain data line low. If several devices answer at once, bus arbitration decides between them. When this block loses, it releases the line for the rest of the transfer and does not count the transfer as serviced.

A serviced alert disarms the responder. It stays silent to further alert-response reads until `alert_active` has been seen low at least once. This holds even if the alert source is slow to withdraw its request.

Top module: `smbus_ara_responder`

## Requirements
- R1: While reset is applied, `sda_pull` and `serviced` are 0.
- R2: When the address byte after a START is the alert response address 7'b0001100 followed by read bit 1, and `alert_active` is 1 and the responder is armed, the block pulls SDA low from the SCL fall after the eighth bit until the SCL fall after the ninth clock (the acknowledge).
- R3: After the acknowledge, the block sends the byte {DEV_ADDR, 1'b0} MSB first (0x98 for the default address 0x4C). A 0 bit is sent by pulling SDA low. Each bit is driven from an SCL fall to the next SCL fall.
- R4: With `alert_active` at 0, an alert-response read gets no acknowledge and no data: SDA stays released for the whole transfer.
- R5: Any other address, or the alert response address with the write bit (0), leaves SDA released.
- R6: After the eighth data bit, SDA is released for the master's acknowledge slot and stays released until the next START.
- R7: `serviced` is a single-cycle pulse. It rises on the cycle after the STOP pulse, and only when all eight data bits and the master's acknowledge slot have been clocked out since the last START. A repeated START in place of the STOP gives no pulse.
- R8: After a `serviced` pulse, alert-response reads are ignored until `alert_active` has been observed at 0.
- R9: If a data bit is sent as 1 (released) but SDA reads 0 at the SCL rise, the block releases SDA for the rest of the transfer and gives no `serviced` pulse.
- R10: A START or STOP at any point abandons the transfer in progress. SDA is released on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl | input | 1 | Synchronised SMBus clock line |
| sda | input | 1 | Synchronised SMBus data line (wired-AND bus level) |
| bus_start | input | 1 | One-cycle pulse from the shared START detector |
| bus_stop | input | 1 | One-cycle pulse from the shared STOP detector |
| alert_active | input | 1 | Local alert request, 1 = asserted |
| sda_pull | output | 1 | 1 = pull SDA low |
| serviced | output | 1 | One-cycle pulse when the alert response was delivered |

## Verification
The block sees an SCL edge at the first clock edge after the line changes. It updates `sda_pull` at that same edge, so a new drive level is due one clock after an SCL fall. The level is then held through the whole high phase. The bench's reference model changes its expected drive level at the moment the bench lowers SCL. The model then lets three clocks pass before it compares again, and after that it compares `sda_pull` on every clock. `serviced` is due on the clock after the STOP pulse is sampled. The bench counts pulses four clocks after each STOP and flags any pulse that lasts two cycles.

// File: rtl/smbus_ara_responder.sv
module smbus_ara_responder #(
  parameter int ADDR_W = 7,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h4C,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic alert_active,
  output logic sda_pull,
  output logic serviced
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACKW, S_ACK, S_TX, S_MACK, S_DONE, S_IGN} st_t;

  st_t st;
  logic scl_q;
  logic armed;
  logic [BYTE_W-1:0] sh;
  logic [CW-1:0] cnt;

  wire rise = scl & ~scl_q;
  wire fall = ~scl & scl_q;
  wire [BYTE_W-1:0] addr_in = {sh[BYTE_W-2:0], sda};
  wire hit = (addr_in == {ARA_ADDR, 1'b1}) && alert_active && armed;

  assign sda_pull = (st == S_ACK) || (st == S_TX && !sh[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      scl_q <= 1'b1;
      armed <= 1'b1;
      sh <= '0;
      cnt <= '0;
      serviced <= 1'b0;
    end else begin
      scl_q <= scl;
      serviced <= 1'b0;
      if (!alert_active) armed <= 1'b1;
      if (bus_stop) begin
        if (st == S_DONE) begin
          serviced <= 1'b1;
          armed <= 1'b0;
        end
        st <= S_IDLE;
      end else if (bus_start) begin
        st <= S_ADDR;
        cnt <= '0;
        sh <= '0;
      end else begin
        case (st)
          S_ADDR: if (rise) begin
            sh <= addr_in;
            if (cnt == LAST) st <= hit ? S_ACKW : S_IGN;
            else cnt <= cnt + 1'b1;
          end
          S_ACKW: if (fall) st <= S_ACK;
          S_ACK: if (fall) begin
            st <= S_TX;
            sh <= {DEV_ADDR, 1'b0};
            cnt <= '0;
          end
          S_TX: begin
            if (rise && sh[BYTE_W-1] && !sda) st <= S_IGN;
            else if (fall) begin
              if (cnt == LAST) st <= S_MACK;
              else begin
                sh <= {sh[BYTE_W-2:0], 1'b0};
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_MACK: if (rise) st <= S_DONE;
          default: ;
        endcase
      end
    end
  end
endmodule

module ara_resp_checks (
  input logic clk,
  input logic rst_n,
  input logic scl,
  input logic bus_start,
  input logic bus_stop,
  input logic sda_pull,
  input logic serviced,
  input logic armed
);
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> (!sda_pull && !serviced));

  p_high_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && !$past(bus_start) && !$past(bus_stop)) |-> $stable(sda_pull));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    serviced |=> !serviced);

  p_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serviced) |-> $past(bus_stop));

  p_rise_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(armed));

  p_abort_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || bus_stop) |=> !sda_pull);
endmodule

bind smbus_ara_responder ara_resp_checks u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl), .bus_start(bus_start), .bus_stop(bus_stop),
  .sda_pull(sda_pull), .serviced(serviced), .armed(armed)
);

// File: tb/tb_smbus_ara_responder.sv
module tb_smbus_ara_responder;
  localparam logic [6:0] DEV = 7'h4C;
  localparam logic [6:0] ARA = 7'h0C;
  localparam logic [7:0] OWN_BYTE = {DEV, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, m_sda = 1'b1, other_pull = 1'b0;
  logic bus_start = 1'b0, bus_stop = 1'b0, alert_active = 1'b0;
  logic sda_pull, serviced;
  wire sda = m_sda & ~sda_pull & ~other_pull;

  int checks = 0, errors = 0, settle = 5, svc_seen = 0, exp_svc = 0;
  logic exp_pull = 1'b0, svc_prev = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  smbus_ara_responder dut (
    .clk(clk), .rst_n(rst_n), .scl(scl), .sda(sda), .bus_start(bus_start),
    .bus_stop(bus_stop), .alert_active(alert_active), .sda_pull(sda_pull), .serviced(serviced)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (settle > 0) settle--;
      else check(sda_pull === exp_pull, cur_req, int'(sda_pull), int'(exp_pull));
      if (serviced) begin
        svc_seen++;
        if (svc_prev) check(1'b0, "R7 pulse width", 2, 1);
      end
      svc_prev = serviced;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bit_cyc(input logic mb, input logic e, input logic oth, input string tag,
                         output logic seen);
    m_sda = mb; other_pull = oth; exp_pull = e; cur_req = tag; settle = 3;
    tick(8); scl = 1'b1; tick(4); seen = sda; tick(4); scl = 1'b0;
  endtask

  task automatic start_cond();
    exp_pull = 1'b0; other_pull = 1'b0; cur_req = "R10"; settle = 3;
    m_sda = 1'b1; tick(4); scl = 1'b1; tick(4); m_sda = 1'b0;
    bus_start = 1'b1; tick(1); bus_start = 1'b0; tick(4); scl = 1'b0;
  endtask

  task automatic stop_cond();
    exp_pull = 1'b0; other_pull = 1'b0; cur_req = "R10"; settle = 3;
    m_sda = 1'b0; tick(4); scl = 1'b1; tick(4); m_sda = 1'b1;
    bus_stop = 1'b1; tick(1); bus_stop = 1'b0; tick(4);
  endtask

  task automatic send_addr(input logic [7:0] b, input logic e_ack, input logic oth_ack,
                           input string tag, output logic ack);
    logic s;
    start_cond();
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], 1'b0, 1'b0, tag, s);
    bit_cyc(1'b1, e_ack, oth_ack, "R2", ack);
  endtask

  task automatic read_data(input logic respond, input logic oth_en, input logic [7:0] oth_b,
                           output logic [7:0] d);
    logic lost, s;
    lost = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      logic e;
      e = respond && !lost && !OWN_BYTE[i];
      bit_cyc(1'b1, e, oth_en && !oth_b[i], "R3", s);
      d[i] = s;
      if (respond && OWN_BYTE[i] && !s) lost = 1'b1;
    end
    bit_cyc(1'b1, 1'b0, 1'b0, "R6", s);
  endtask

  task automatic ara_txn(input logic respond, input string tag, input logic [7:0] exp_d);
    logic ack;
    logic [7:0] d;
    send_addr({ARA, 1'b1}, respond, 1'b0, tag, ack);
    check(ack == !respond, {tag, " ack level"}, int'(ack), int'(!respond));
    read_data(respond, 1'b0, 8'hFF, d);
    check(d == exp_d, {tag, " data byte"}, int'(d), int'(exp_d));
  endtask

  task automatic svc_check(input string tag);
    check(svc_seen == exp_svc, {tag, " serviced count"}, svc_seen, exp_svc);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    tick(3);
    check(sda_pull == 1'b0, "R1 sda_pull in reset", int'(sda_pull), 0);
    check(serviced == 1'b0, "R1 serviced in reset", int'(serviced), 0);
    rst_n = 1'b1; tick(4);

    alert_active = 1'b1; tick(2);
    ara_txn(1'b1, "R2", OWN_BYTE);
    stop_cond(); exp_svc++; svc_check("R7");

    ara_txn(1'b0, "R8", 8'hFF);
    stop_cond(); svc_check("R8");

    alert_active = 1'b0; tick(4);
    ara_txn(1'b0, "R4", 8'hFF);
    stop_cond(); svc_check("R4");

    alert_active = 1'b1; tick(4);
    send_addr({ARA, 1'b0}, 1'b0, 1'b0, "R5", ack);
    check(ack == 1'b1, "R5 write bit ignored", int'(ack), 1);
    stop_cond();
    send_addr({DEV, 1'b1}, 1'b0, 1'b0, "R5", ack);
    check(ack == 1'b1, "R5 other address ignored", int'(ack), 1);
    stop_cond(); svc_check("R5");

    ara_txn(1'b1, "R3", OWN_BYTE);
    send_addr({DEV, 1'b0}, 1'b0, 1'b0, "R10", ack);
    check(ack == 1'b1, "R10 restart address ignored", int'(ack), 1);
    stop_cond(); svc_check("R7 restart no pulse");
    ara_txn(1'b1, "R6", OWN_BYTE);
    stop_cond(); exp_svc++; svc_check("R7");

    alert_active = 1'b0; tick(4); alert_active = 1'b1; tick(4);
    start_cond();
    for (int i = 7; i >= 4; i--) bit_cyc(ARA[i-1], 1'b0, 1'b0, "R10", ack);
    stop_cond(); svc_check("R10 abort");

    send_addr({ARA, 1'b1}, 1'b1, 1'b1, "R9", ack);
    check(ack == 1'b0, "R9 ack level", int'(ack), 0);
    read_data(1'b1, 1'b1, 8'h30, d);
    check(d == 8'h30, "R9 winner byte", int'(d), 8'h30);
    stop_cond(); svc_check("R9 no pulse after loss");

    ara_txn(1'b1, "R3", OWN_BYTE);
    stop_cond(); exp_svc++; svc_check("R7");

    tick(10);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule